// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block fills a missing address translation by walking a two-level page table held in physical memory. A miss request carries a 32-bit virtual address. The block takes the first-level table base from a root register that supervisor software writes. It then reads the first-level entry and, if that entry is present, the second-level entry. Page tables sit in untranslated physical memory, so every read the walker issues uses a physical address with no translation applied.

A walk ends in one of two ways. When both entries are present, the block returns the physical page number and the permission bits so that the TLB can be refilled. When an entry at either level is absent, the block stops at once and reports a page fault for the original access. In that case it supplies no refill data and issues no further reads.

Only one walk runs at a time. The miss request and the memory read request are valid/ready streams, and a request is transferred on a cycle where valid and ready are both high. The miss port takes back-pressure through `req_ready`, which stays low for the whole walk. The memory port takes back-pressure through `mem_req_ready`, and while it is low the walker holds its read request steady. Read data returns on a response-valid strobe that cannot be stalled. Any number of wait cycles may come before the grant, and any number between the grant and the response.

Top module: `pt_walker`

## Requirements
- R1: The first read of a walk goes to root + 4 * va[31:22]. Both the root and the virtual address are sampled in the cycle the miss request is accepted.
- R2: The second read goes to {L1[31:12], 12'h000} + 4 * va[21:12], where L1 is the first-level entry that was read.
- R3: While `mem_req_valid` is high and `mem_req_ready` is low, the next cycle keeps `mem_req_valid` high and keeps `mem_req_addr` unchanged.
- R4: If bit 0 (present) of the first-level entry is 0, the walk ends with fault=1 and fault_level=0, and no second read is issued.
- R5: If the present bit of the second-level entry is 0, the walk ends with fault=1 and fault_level=1.
- R6: On success the walk ends with fault=0, resp_ppn = L2[31:12] and resp_perm = L2[4:1].
- R7: `req_ready` is the inverse of `busy`. A miss request offered while busy is ignored and does not change the result of the walk in progress. Changes to root or to the virtual address after acceptance have no effect.
- R8: `done` is high for exactly one cycle, in the cycle after the clock edge that takes in the final response. The result outputs are valid in that cycle, and `busy` is low in the cycle after it.
- R9: After reset, busy, done, fault and mem_req_valid are 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request offered |
| req_ready | output | 1 | Miss request can be accepted |
| req_vaddr | input | 32 | Virtual address of the miss |
| root_base | input | 32 | Physical byte address of the first-level table |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Physical byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Walk ended in a page fault |
| fault_level | output | 1 | 0: first-level entry absent, 1: second-level entry absent |
| resp_ppn | output | 20 | Physical page number for the refill |
| resp_perm | output | 4 | Permission bits for the refill |

## Verification
The first read request is visible in the cycle after the miss request is accepted. After a successful first-level response, the second read request is visible in the cycle after that response edge. `done` and the result fields appear in the cycle after the final response edge, and `busy` drops one cycle later. The bench drives on falling edges and samples on the falling edge that comes right after each of these edges. In that way it checks request addresses, the hold behaviour under stall, the end pulse and the absence of extra reads. The sweep covers grant and response delays of 0 to 2 cycles, and index values at 0, at 1023 and in between.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ1,
    ST_WAIT1,
    ST_REQ2,
    ST_WAIT2,
    ST_RESP
  } walk_state_t;

  localparam int PRESENT_BIT = 0;
  localparam int PERM_LSB    = 1;
endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
  parameter int VA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic [VA_W-1:0]  vaddr,
  output logic [IDX_W-1:0] idx1,
  output logic [IDX_W-1:0] idx2,
  output logic [OFF_W-1:0] offset
);
  always_comb begin
    idx1   = vaddr[OFF_W+IDX_W +: IDX_W];
    idx2   = vaddr[OFF_W +: IDX_W];
    offset = vaddr[OFF_W-1:0];
  end
endmodule

// File: rtl/pt_pte_decode.sv
module pt_pte_decode
  import pt_walker_pkg::*;
#(
  parameter int PTE_W  = 32,
  parameter int OFF_W  = 12,
  parameter int PERM_W = 4
) (
  input  logic [PTE_W-1:0]       pte,
  output logic                   present,
  output logic [PTE_W-OFF_W-1:0] ppn,
  output logic [PERM_W-1:0]      perm
);
  always_comb begin
    present = pte[PRESENT_BIT];
    ppn     = pte[PTE_W-1:OFF_W];
    perm    = pte[PERM_LSB +: PERM_W];
  end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
#(
  parameter int PA_W   = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int PERM_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  idx1,
  input  logic [IDX_W-1:0]  idx2,
  input  logic [PA_W-1:0]   root_base,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic              pte_present,
  input  logic [PA_W-OFF_W-1:0] pte_ppn,
  input  logic [PERM_W-1:0] pte_perm,
  output logic              done,
  output logic              fault,
  output logic              fault_level,
  output logic [PA_W-OFF_W-1:0] resp_ppn,
  output logic [PERM_W-1:0] resp_perm
);
  localparam int ENT_SH = $clog2(PA_W / 8);
  localparam int PAD_W  = PA_W - IDX_W - ENT_SH;

  walk_state_t state_q;
  logic [IDX_W-1:0] idx2_q;
  logic [PA_W-1:0]  addr_q;
  logic [PA_W-1:0]  l1_addr, l2_addr;
  logic             accept;

  always_comb begin
    l1_addr = root_base + {{PAD_W{1'b0}}, idx1, {ENT_SH{1'b0}}};
    l2_addr = {pte_ppn, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, idx2_q, {ENT_SH{1'b0}}};
    busy          = (state_q != ST_IDLE);
    req_ready     = !busy;
    accept        = req_valid && req_ready;
    mem_req_valid = (state_q == ST_REQ1) || (state_q == ST_REQ2);
    mem_req_addr  = addr_q;
    done          = (state_q == ST_RESP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      idx2_q      <= '0;
      addr_q      <= '0;
      fault       <= 1'b0;
      fault_level <= 1'b0;
      resp_ppn    <= '0;
      resp_perm   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          idx2_q  <= idx2;
          addr_q  <= l1_addr;
          fault   <= 1'b0;
          state_q <= ST_REQ1;
        end
        ST_REQ1: if (mem_req_ready) state_q <= ST_WAIT1;
        ST_WAIT1: if (mem_rsp_valid) begin
          if (pte_present) begin
            addr_q  <= l2_addr;
            state_q <= ST_REQ2;
          end else begin
            fault       <= 1'b1;
            fault_level <= 1'b0;
            state_q     <= ST_RESP;
          end
        end
        ST_REQ2: if (mem_req_ready) state_q <= ST_WAIT2;
        ST_WAIT2: if (mem_rsp_valid) begin
          fault       <= !pte_present;
          fault_level <= 1'b1;
          resp_ppn    <= pte_ppn;
          resp_perm   <= pte_perm;
          state_q     <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_done_after_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_rsp_valid));

  assert_no_read_after_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault && !fault_level |=> !mem_req_valid);
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W   = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int PTE_W  = 32,
  parameter int PERM_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic [PTE_W-1:0]       root_base,
  output logic                   busy,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [PTE_W-1:0]       mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [PTE_W-1:0]       mem_rsp_data,
  output logic                   done,
  output logic                   fault,
  output logic                   fault_level,
  output logic [PTE_W-OFF_W-1:0] resp_ppn,
  output logic [PERM_W-1:0]      resp_perm
);
  localparam int PPN_W = PTE_W - OFF_W;

  logic [IDX_W-1:0]  idx1, idx2;
  logic [OFF_W-1:0]  offset_unused;
  logic              pte_present;
  logic [PPN_W-1:0]  pte_ppn;
  logic [PERM_W-1:0] pte_perm;

  pt_va_split #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
    .vaddr(req_vaddr), .idx1(idx1), .idx2(idx2), .offset(offset_unused)
  );

  pt_pte_decode #(.PTE_W(PTE_W), .OFF_W(OFF_W), .PERM_W(PERM_W)) u_dec (
    .pte(mem_rsp_data), .present(pte_present), .ppn(pte_ppn), .perm(pte_perm)
  );

  pt_walk_fsm #(.PA_W(PTE_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .PERM_W(PERM_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .idx1(idx1), .idx2(idx2), .root_base(root_base),
    .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .pte_present(pte_present), .pte_ppn(pte_ppn), .pte_perm(pte_perm),
    .done(done), .fault(fault), .fault_level(fault_level),
    .resp_ppn(resp_ppn), .resp_perm(resp_perm)
  );

  assert_ready_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_fault_ends_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> done);
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] root_base = '0;
  logic busy;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic done, fault, fault_level;
  logic [19:0] resp_ppn;
  logic [3:0] resp_perm;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .root_base(root_base), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .fault_level(fault_level),
    .resp_ppn(resp_ppn), .resp_perm(resp_perm)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  // Serve one read: wait for a request, stall the grant, then respond.
  task automatic serve(input logic [31:0] exp_addr, input logic [31:0] data,
                       input int gnt_dly, input int rsp_dly, input string tag);
    int n = 0;
    while (!mem_req_valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(mem_req_valid, {tag, " request seen"}, {31'd0, mem_req_valid}, 32'd1);
    chk(mem_req_addr == exp_addr, tag, mem_req_addr, exp_addr);
    for (int k = 0; k < gnt_dly; k++) begin
      @(negedge clk);
      chk(mem_req_valid && mem_req_addr == exp_addr, "R3 hold under stall", mem_req_addr, exp_addr);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    for (int k = 0; k < rsp_dly; k++) @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = data;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'hDEAD_BEEF;
  endtask

  // mode 0: success, 1: first-level absent, 2: second-level absent
  task automatic walk(input logic [31:0] va, input logic [31:0] root, input int mode,
                      input int gdly, input int rdly);
    logic [31:0] l1, l2, a1, a2;
    l1 = {20'(va[31:12] ^ 20'h5A3C1 ^ root[31:12]), 11'h2AA, 1'b1};
    if (mode == 1) l1[0] = 1'b0;
    l2 = {20'(va[31:12] * 3 + 20'h00777), 7'(va[6:0]), 4'(va[15:12] ^ va[25:22]), 1'b1};
    if (mode == 2) l2[0] = 1'b0;
    a1 = root + {20'd0, va[31:22], 2'b00};
    a2 = {l1[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    root_base = root;
    chk(req_ready, "R7 ready when idle", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    chk(busy && !req_ready, "R7 busy after accept", {31'd0, req_ready}, 32'd0);
    // offer another request and change root/va while busy: must be ignored
    req_vaddr = ~va;
    root_base = root ^ 32'h00F0_0000;
    chk(mem_req_addr == a1, "R1 first read address", mem_req_addr, a1);
    serve(a1, l1, gdly, rdly, "R1 first read address");
    req_valid = 1'b0;
    if (mode == 1) begin
      chk(done && fault && !fault_level, "R4 fault level 0",
          {29'd0, done, fault, fault_level}, 32'b110);
      chk(!mem_req_valid, "R4 no second read", {31'd0, mem_req_valid}, 32'd0);
    end else begin
      chk(!done, "R8 no early done", {31'd0, done}, 32'd0);
      serve(a2, l2, rdly, gdly, "R2 second read address");
      if (mode == 2)
        chk(done && fault && fault_level, "R5 fault level 1",
            {29'd0, done, fault, fault_level}, 32'b111);
      else begin
        chk(done && !fault, "R6 success", {30'd0, done, fault}, 32'b10);
        chk(resp_ppn == l2[31:12], "R6 ppn", {12'd0, resp_ppn}, {12'd0, l2[31:12]});
        chk(resp_perm == l2[4:1], "R6 perm", {28'd0, resp_perm}, {28'd0, l2[4:1]});
      end
    end
    @(negedge clk);
    chk(!done && !busy && !mem_req_valid, "R8 single pulse then idle",
        {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !mem_req_valid && req_ready, "R9 reset state",
        {27'd0, busy, done, fault, mem_req_valid, req_ready}, 32'b00001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && req_ready, "R9 idle after reset", {31'd0, busy}, 32'd0);
    walk(32'h0000_0000, 32'h0000_4000, 0, 0, 0);
    walk(32'hFFFF_FFFF, 32'h0010_0000, 0, 2, 1);
    walk(32'hFFC0_0ABC, 32'h0020_0004, 1, 1, 0);
    walk(32'h003F_F123, 32'h0030_0008, 2, 0, 2);
    for (int i = 0; i < 96; i++) begin
      logic [31:0] va, root;
      va   = {10'(i * 37), 10'((i * 91) ^ 1023), 12'(i * 5)};
      root = 32'(i) * 32'h0001_3004 + 32'h0000_4000;
      walk(va, root, i % 3, i % 3, (i / 3) % 3);
    end
    finish_run();
  end
endmodule